// File: doc/BRIEF.md
# Two-Section Linear Imager Readout Sequencer

This block is the digital timing core of a 256-pixel line imager. The line is split into two sections of 128 pixels each. A single start pulse freezes the exposure of every pixel at once by issuing one hold strobe. It then opens a fixed-length window in which all pixel integrators are cleared, and walks a start token across the pixels of each section one clock at a time. While the token is inside a section, that section's output-enable is high and its pixel-select index names the pixel being read. When the token leaves, the section raises a one-clock serial output. That output can start a following section or device, or mark the end of the data.

The two sections run in one of two ways. In chained mode, the serial output of section 1 starts section 2, so a full line takes 256 clocks. In parallel mode, each section has its own start input and both finish in 128 clocks. A start that arrives while a readout is still under way is honoured, and the protocol-error flag is raised alongside it. Only the control timing is modelled: the photodiodes, the sample capacitors and the analog output path are not.

Top module: `lsa_readout_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every output is 0: all strobes and flags are low and both indices are 0.
- R2: A start for section 1 is the rising edge of `si1_i` seen on a clock edge, called edge 1. After edge 1, `oe1_o` is 1 and `idx1_o` is 0. An input that stays high for several clocks counts as a single start.
- R3: `hold_o` is high for exactly the one cycle that follows edge 1. Only a section-1 start produces it.
- R4: `integ_rst_o` is high for the 18 cycles that follow edges 1 through 18. `integ_on_o` rises after edge 19 and stays high until the next section-1 start. It is 0 from reset until the first window completes, and it is never high together with `integ_rst_o`.
- R5: While a section's output-enable is high, its index counts 0 to 127 and rises by one per clock. While the section is idle, the index reads 0.
- R6: `so1_o` is high only in the cycle after edge 128, while `idx1_o` is 127. Edge 129 clears both `so1_o` and `oe1_o`.
- R7: With `chain_i`=1, section 2 starts on edge 129 from section 1's serial output. `so2_o` is high after edge 256, `oe2_o` falls after edge 257, and `si2_i` has no effect on any output.
- R8: With `chain_i`=0, section 2 starts from the rising edge of `si2_i`, on the same relative timing as section 1. A line then takes 128 clocks.
- R9: A section-1 start that arrives while either section is enabled restarts section 1 at index 0 and issues a new hold and reset window. In chained mode it also stops section 2. `proto_err_o` is high for the cycle that follows.
- R10: With `chain_i`=0, a section-2 start that arrives while section 2 is enabled restarts section 2 at index 0 and raises `proto_err_o` for one cycle. It does not touch hold or section 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chain_i | input | 1 | 1 = section 2 fed from section 1 serial output; 0 = independent starts |
| si1_i | input | 1 | Section 1 start pulse |
| si2_i | input | 1 | Section 2 start pulse (used when chain_i = 0) |
| hold_o | output | 1 | One-cycle global hold strobe |
| integ_rst_o | output | 1 | Integrator reset window |
| integ_on_o | output | 1 | Pixels are integrating |
| oe1_o | output | 1 | Section 1 output driven (not high impedance) |
| idx1_o | output | 7 | Section 1 pixel-select index |
| so1_o | output | 1 | Section 1 serial output |
| oe2_o | output | 1 | Section 2 output driven |
| idx2_o | output | 7 | Section 2 pixel-select index |
| so2_o | output | 1 | Section 2 serial output |
| proto_err_o | output | 1 | Start seen during a readout in progress |

## Verification
A clean single start in chained mode shows whether the token crosses from section 1 into section 2 on the right edge, and whether each enable drops exactly one clock after its serial pulse. A start held high for several clocks tells edge capture apart from level capture. Starts placed inside section 1, and others placed inside section 2, separate the restart, the kill of section 2 and the error flag from normal readout. Parallel runs with joint and separate starts, together with random pulse trains in both modes that include back-to-back and overlapping pulses, compare every output on every cycle against a model based on cycle counts.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
  localparam int unsigned PIX_DEF  = 128;  // pixels per section
  localparam int unsigned RCLK_DEF = 18;   // integrator reset window length
  localparam int unsigned NSEC     = 2;    // sections in the line

  typedef enum logic {
    LINK_PARALLEL = 1'b0,
    LINK_CHAIN    = 1'b1
  } link_mode_e;
endpackage

// File: rtl/lsa_section.sv
`timescale 1ns/1ps
// One section: a start token walks pixel positions 0..PIX-1, one per clock.
module lsa_section #(
  parameter int unsigned PIX = 128,
  parameter int unsigned IW  = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          kill_i,
  output logic          oe_o,
  output logic [IW-1:0] idx_o,
  output logic          so_o
);
  localparam logic [IW-1:0] LAST = IW'(PIX - 1);
  localparam logic [IW-1:0] ONE  = IW'(1);

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      oe_o  <= 1'b0;
      idx_o <= '0;
      so_o  <= 1'b0;
    end else if (start_i) begin
      oe_o  <= 1'b1;
      idx_o <= '0;
      so_o  <= (LAST == '0);
    end else if (oe_o) begin
      if (idx_o == LAST) begin
        oe_o  <= 1'b0;
        idx_o <= '0;
        so_o  <= 1'b0;
      end else begin
        idx_o <= idx_o + ONE;
        so_o  <= ((idx_o + ONE) == LAST);
      end
    end else begin
      so_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lsa_hold_ctl.sv
`timescale 1ns/1ps
// Global hold strobe, integrator reset window and integration flag.
module lsa_hold_ctl #(
  parameter int unsigned RCLK = 18,
  parameter int unsigned CW   = $clog2(RCLK + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic hold_o,
  output logic win_o,
  output logic integ_o
);
  localparam logic [CW-1:0] LAST = CW'(RCLK);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o  <= 1'b0;
      win_o   <= 1'b0;
      integ_o <= 1'b0;
      cnt_q   <= '0;
    end else begin
      hold_o <= start_i;
      if (start_i) begin
        win_o   <= 1'b1;
        integ_o <= 1'b0;
        cnt_q   <= ONE;
      end else if (win_o) begin
        if (cnt_q == LAST) begin
          win_o   <= 1'b0;
          integ_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/lsa_readout_seq.sv
`timescale 1ns/1ps
module lsa_readout_seq #(
  parameter int unsigned PIX  = lsa_pkg::PIX_DEF,
  parameter int unsigned RCLK = lsa_pkg::RCLK_DEF,
  parameter int unsigned IW   = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chain_i,
  input  logic          si1_i,
  input  logic          si2_i,
  output logic          hold_o,
  output logic          integ_rst_o,
  output logic          integ_on_o,
  output logic          oe1_o,
  output logic [IW-1:0] idx1_o,
  output logic          so1_o,
  output logic          oe2_o,
  output logic [IW-1:0] idx2_o,
  output logic          so2_o,
  output logic          proto_err_o
);
  import lsa_pkg::*;

  logic [NSEC-1:0] src, src_q, st, kill, sec_oe, sec_so;
  logic [IW-1:0]   sec_idx [NSEC];
  logic            chained, err_ev;

  assign chained = (link_mode_e'(chain_i) == LINK_CHAIN);

  // start sources: section 2 takes section 1's serial output when chained
  always_comb begin
    src[0] = si1_i;
    src[1] = chained ? sec_so[0] : si2_i;
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  assign st = src & ~src_q;   // rising-edge capture, one start per pulse

  // a section-1 restart in chained mode withdraws the token from section 2
  always_comb begin
    kill    = '0;
    kill[1] = chained & st[0];
  end

  assign err_ev = (st[0] & (sec_oe[0] | sec_oe[1])) |
                  (~chained & st[1] & sec_oe[1]);

  always_ff @(posedge clk) begin
    if (rst) proto_err_o <= 1'b0;
    else     proto_err_o <= err_ev;
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    lsa_section #(.PIX(PIX), .IW(IW)) u_sec (
      .clk    (clk),
      .rst    (rst),
      .start_i(st[g]),
      .kill_i (kill[g]),
      .oe_o   (sec_oe[g]),
      .idx_o  (sec_idx[g]),
      .so_o   (sec_so[g])
    );
  end

  lsa_hold_ctl #(.RCLK(RCLK)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .start_i(st[0]),
    .hold_o (hold_o),
    .win_o  (integ_rst_o),
    .integ_o(integ_on_o)
  );

  assign oe1_o  = sec_oe[0];
  assign idx1_o = sec_idx[0];
  assign so1_o  = sec_so[0];
  assign oe2_o  = sec_oe[1];
  assign idx2_o = sec_idx[1];
  assign so2_o  = sec_so[1];
endmodule

// File: rtl/lsa_readout_chk.sv
`timescale 1ns/1ps
module lsa_readout_chk #(
  parameter int unsigned PIX = 128,
  parameter int unsigned IW  = $clog2(PIX)
) (
  input logic          clk,
  input logic          rst,
  input logic          hold_o,
  input logic          integ_rst_o,
  input logic          integ_on_o,
  input logic          oe1_o,
  input logic [IW-1:0] idx1_o,
  input logic          so1_o,
  input logic          oe2_o,
  input logic [IW-1:0] idx2_o,
  input logic          so2_o
);
  localparam logic [IW-1:0] LAST = IW'(PIX - 1);

  p_hold_single_r3: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> !hold_o);

  p_win_integ_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(integ_rst_o && integ_on_o));

  p_hold_opens_win_r4: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> (integ_rst_o && !integ_on_o));

  p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
    (oe1_o && $past(oe1_o) && idx1_o != '0) |-> (idx1_o == $past(idx1_o) + IW'(1)));

  p_idle_idx_r5: assert property (@(posedge clk) disable iff (rst)
    !oe1_o |-> (idx1_o == '0));

  p_so1_last_r6: assert property (@(posedge clk) disable iff (rst)
    so1_o |-> (oe1_o && idx1_o == LAST));

  p_so1_single_r6: assert property (@(posedge clk) disable iff (rst)
    so1_o |=> !so1_o);

  p_so2_last_r7: assert property (@(posedge clk) disable iff (rst)
    so2_o |-> (oe2_o && idx2_o == LAST));
endmodule

bind lsa_readout_seq lsa_readout_chk #(.PIX(PIX), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold_o     (hold_o),
  .integ_rst_o(integ_rst_o),
  .integ_on_o (integ_on_o),
  .oe1_o      (oe1_o),
  .idx1_o     (idx1_o),
  .so1_o      (so1_o),
  .oe2_o      (oe2_o),
  .idx2_o     (idx2_o),
  .so2_o      (so2_o)
);

// File: tb/lsa_readout_seq_tb.sv
`timescale 1ns/1ps
module lsa_readout_seq_tb_top;
  localparam int PIX = 128;
  localparam int RCL = 18;
  localparam int CAP = 400;

  logic clk = 1'b0, rst = 1'b1, chain = 1'b1, si1 = 1'b0, si2 = 1'b0;
  logic hold, wnd, integ, oe1, so1, oe2, so2, perr;
  logic [6:0] idx1, idx2;

  int checks = 0, errs = 0;
  int t1 = 0, t2 = 0;
  bit p1 = 0, p2 = 0, e_err = 0, done = 0;

  always #2 clk = ~clk;

  lsa_readout_seq dut_i (
    .clk(clk), .rst(rst), .chain_i(chain), .si1_i(si1), .si2_i(si2),
    .hold_o(hold), .integ_rst_o(wnd), .integ_on_o(integ),
    .oe1_o(oe1), .idx1_o(idx1), .so1_o(so1),
    .oe2_o(oe2), .idx2_o(idx2), .so2_o(so2), .proto_err_o(perr));

  function automatic bit in_rng(int t, int lo, int hi);
    return (t >= lo) && (t <= hi);
  endfunction

  // expected section-2 position counted from its own start
  function automatic int sec2_t();
    return chain ? ((t1 > PIX) ? t1 - PIX : 0) : t2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d (t1=%0d t2=%0d)", req, what, act, exp, t1, t2);
    end
  endtask

  task automatic model_update();
    bit s1, s2, b1, b2;
    if (rst) begin
      t1 = 0; t2 = 0; p1 = 0; p2 = 0; e_err = 0;
    end else begin
      s1 = si1 && !p1;
      s2 = !chain && si2 && !p2;
      p1 = si1; p2 = si2;
      b1 = in_rng(t1, 1, PIX);
      b2 = in_rng(sec2_t(), 1, PIX);
      e_err = (s1 && (b1 || b2)) || (s2 && b2);
      if (s1) t1 = 1; else if (t1 > 0 && t1 < CAP) t1++;
      if (s2) t2 = 1; else if (t2 > 0 && t2 < CAP) t2++;
    end
  endtask

  task automatic compare_all();
    int u2 = sec2_t();
    string r2 = chain ? "R7" : "R8";
    chk("R3", "hold", hold, t1 == 1);
    chk("R4", "integ_rst", wnd, in_rng(t1, 1, RCL));
    chk("R4", "integ_on", integ, t1 >= RCL + 1);
    chk("R2", "oe1", oe1, in_rng(t1, 1, PIX));
    chk("R5", "idx1", idx1, in_rng(t1, 1, PIX) ? t1 - 1 : 0);
    chk("R6", "so1", so1, t1 == PIX);
    chk(r2, "oe2", oe2, in_rng(u2, 1, PIX));
    chk(r2, "idx2", idx2, in_rng(u2, 1, PIX) ? u2 - 1 : 0);
    chk(r2, "so2", so2, u2 == PIX);
    chk(chain ? "R9" : "R10", "proto_err", perr, e_err);
  endtask

  task automatic step(bit a, bit b);
    si1 = a; si2 = b;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n, bit noisy2);
    for (int i = 0; i < n; i++) step(1'b0, noisy2 ? 1'($urandom % 3 == 0) : 1'b0);
  endtask

  task automatic do_reset(bit mode);
    rst = 1'b1; chain = mode; si1 = 1'b0; si2 = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); model_update();
    end
    @(negedge clk);
    rst = 1'b0;
    // R1: everything clear while held in reset
    chk("R1", "reset outputs", {hold, wnd, integ, oe1, so1, oe2, so2, perr, idx1, idx2}, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    // chained: one clean line, si2 noise must be ignored (R7)
    do_reset(1'b1);
    step(1'b0, 1'b0);   // R1: first cycle after release still clear
    step(1'b1, 1'b0);
    idle(300, 1'b1);
    // R2: start held high for four clocks counts once
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    idle(50, 1'b0);
    // R9: restart inside section 1, then inside section 2
    step(1'b1, 1'b0);
    idle(150, 1'b0);
    step(1'b1, 1'b0);
    idle(127, 1'b0);
    step(1'b1, 1'b0);   // restart exactly on the token hand-over edge
    idle(300, 1'b0);
    // parallel: joint start (R8), separate start, restart of section 2 (R10)
    do_reset(1'b0);
    step(1'b1, 1'b1);
    idle(140, 1'b0);
    step(1'b0, 1'b1);
    idle(40, 1'b0);
    step(1'b0, 1'b1);
    idle(20, 1'b0);
    step(1'b1, 1'b0);
    idle(200, 1'b0);
    // random pulse trains in both modes
    for (int blk = 0; blk < 6; blk++) begin
      do_reset(blk[0]);
      for (int i = 0; i < 700; i++)
        step(1'($urandom % 90 == 0), 1'($urandom % 70 == 0));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule